// File: doc/BRIEF.md
# Memory Block Move Sequencer

This block copies bytes from one place in memory to another over a simple 8-bit memory bus. Software, or a processor's microcode, loads a source pointer, a destination pointer, a byte count and a mode byte, then pulses `start`. Each byte costs exactly two bus cycles. The first is a read at the source pointer. The second is a write of that byte to the destination pointer. Each pointer then steps by the rule the mode byte gives it: hold, up by one or down by one. The count is loaded as the true number of bytes and drops by one while the read is on the bus. This means the zero flag already shows the final state during the matching write.

One mode bit chooses between two kinds of run. In repeat mode the engine keeps going until the count runs out, and a new `start` cannot break in. In single mode it moves one byte and stops. The updated pointers, count and zero flag are then visible, so a software loop can feed them back and restart the engine between interrupts. Reads are asynchronous: `mem_rdata` must be valid while `mem_rd` is high, and it is captured at the clock edge that ends the read cycle.

Top module: `mem_copy_seq`

## Requirements
- R1: After reset: `busy`, `done`, `mem_rd` and `mem_wr` are 0, both pointers and the count read 0, and `zero_flag` reads 1.
- R2: A `start` sampled while idle with a nonzero count is followed by a read cycle at the source pointer in the next cycle. The cycle after that is a write cycle at the destination pointer, and `mem_wdata` carries the byte returned by that read.
- R3: The count is loaded with the actual byte count. It drops by one at the end of each read cycle. During each write cycle `zero_flag` is 1 exactly when the count then shown is 0.
- R4: Mode bits [1:0] step the source pointer and bits [3:2] step the destination pointer, using 00 = hold, 01 = +1, 10 = -1 and 11 = hold. The source pointer steps at the end of the read cycle and the destination pointer at the end of the write cycle. Mode bits [7:5] have no effect.
- R5: Pointer stepping wraps modulo 2^16: 0xFFFF + 1 gives 0x0000, and 0x0000 - 1 gives 0xFFFF.
- R6: With mode bit 4 = 1 (repeat), read/write pairs run back to back until the count reaches 0. For N bytes the run takes 2N cycles. `done` is then high for exactly one cycle, in the cycle after the final write, and `busy` is low in that cycle.
- R7: With mode bit 4 = 0 (single), one read/write pair runs, then `done` pulses. The outputs then show both pointers stepped once and the count reduced by one.
- R8: A `start` with a count of 0 produces no bus cycle. `done` pulses in the next cycle, `zero_flag` is 1 and the count reads 0.
- R9: A `start` sampled while a run is in progress is ignored: the run's bus cycles and final results are unchanged.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run; sampled only while idle |
| mode | input | 8 | [1:0] source step, [3:2] destination step, [4] repeat; captured at start |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| len_init | input | 16 | Byte count loaded at start |
| mem_addr | output | 16 | Bus address: source during a read, destination during a write |
| mem_rd | output | 1 | Read cycle in progress |
| mem_wr | output | 1 | Write cycle in progress |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Byte returned by memory during a read cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current remaining count |
| zero_flag | output | 1 | Count is zero |

## Verification
The final write of a run decides whether the run ends, and a new `start` request can arrive in that same cycle. The bench provokes the overlap by pulsing `start` with unrelated pointers and count exactly in the last write cycle, and also in the middle of a run. It judges the result from the bus trace and the final outputs, which must match an unpoked run. A second coincidence is checked on every write cycle: the count decrement lands in the read cycle, while the zero decision is made in the following write cycle. The scoreboard compares `zero_flag` and `cnt_out` against the remaining byte count on each write.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } mcs_state_e;

  // pointer stepping rule, 2 bits per pointer (R4)
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSVD = 2'b11
  } mcs_step_e;

  localparam int MODE_W      = 8;
  localparam int SRC_STEP_LO = 0;
  localparam int DST_STEP_LO = 2;
  localparam int REPEAT_BIT  = 4;
  localparam int NUM_PTR     = 2;   // index 0 = source, 1 = destination

endpackage

// File: rtl/mcs_ptr.sv
module mcs_ptr
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  input  mcs_step_e         step,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic              ptr_en;

  assign ptr_en = load | advance;

  // next value; wraps modulo 2^ADDR_W (R5)
  always_comb begin
    ptr_nxt = ptr_q;
    if (load) begin
      ptr_nxt = load_val;
    end else begin
      unique case (step)
        STEP_INC: ptr_nxt = ptr_q + ADDR_W'(1);
        STEP_DEC: ptr_nxt = ptr_q - ADDR_W'(1);
        default:  ptr_nxt = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/mcs_count.sv
module mcs_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             zero_q, zero_nxt;
  logic             cnt_en;

  assign cnt_en = load | dec;

  // decrement happens in the read cycle so zero is settled for the write (R3)
  always_comb begin
    cnt_nxt  = cnt_q;
    zero_nxt = zero_q;
    if (load) begin
      cnt_nxt  = load_val;
      zero_nxt = (load_val == '0);
    end else if (dec) begin
      cnt_nxt  = cnt_q - CNT_W'(1);
      zero_nxt = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_nxt;
      zero_q <= zero_nxt;
    end
  end

  assign cnt  = cnt_q;
  assign zero = zero_q;

endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              len_zero,
  input  logic              cnt_zero,
  output logic              load,
  output logic              rd_cyc,
  output logic              wr_cyc,
  output logic              busy,
  output logic              done,
  output logic              rep_mode,
  output mcs_step_e         src_step,
  output mcs_step_e         dst_step
);

  mcs_state_e        state_q, state_nxt;
  logic [MODE_W-1:0] mode_q;
  logic              done_q, done_nxt;
  logic              accept;
  logic              again;

  // a start is only seen while idle (R9)
  assign accept = (state_q == ST_IDLE) & start;
  assign again  = mode_q[REPEAT_BIT] & ~cnt_zero;

  always_comb begin
    state_nxt = state_q;
    done_nxt  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (len_zero) done_nxt  = 1'b1;       // R8
          else          state_nxt = ST_READ;
        end
      end
      ST_READ:  state_nxt = ST_WRITE;           // R2
      ST_WRITE: begin
        if (again) begin
          state_nxt = ST_READ;                  // R6
        end else begin
          state_nxt = ST_IDLE;                  // R6 / R7
          done_nxt  = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (accept) begin
      mode_q <= mode_in;
    end
  end

  assign load     = accept;
  assign rd_cyc   = (state_q == ST_READ);
  assign wr_cyc   = (state_q == ST_WRITE);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rep_mode = mode_q[REPEAT_BIT];
  assign src_step = mcs_step_e'(mode_q[SRC_STEP_LO +: 2]);
  assign dst_step = mcs_step_e'(mode_q[DST_STEP_LO +: 2]);

endmodule

// File: rtl/mem_copy_seq.sv
module mem_copy_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] src_init,
  input  logic [ADDR_W-1:0] dst_init,
  input  logic [CNT_W-1:0]  len_init,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              zero_flag
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  logic      load_w, rd_w, wr_w, rep_mode_w, cnt_zero_w;
  mcs_step_e src_step_w, dst_step_w;

  mcs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (start),
    .mode_in  (mode),
    .len_zero (len_init == '0),
    .cnt_zero (cnt_zero_w),
    .load     (load_w),
    .rd_cyc   (rd_w),
    .wr_cyc   (wr_w),
    .busy     (busy),
    .done     (done),
    .rep_mode (rep_mode_w),
    .src_step (src_step_w),
    .dst_step (dst_step_w)
  );

  // pointer pair: 0 = source (steps after read), 1 = destination (after write)
  logic      [NUM_PTR-1:0][ADDR_W-1:0] ptr_init, ptr_val;
  logic      [NUM_PTR-1:0]             ptr_adv;
  mcs_step_e [NUM_PTR-1:0]             ptr_step;

  assign ptr_init[0] = src_init;
  assign ptr_init[1] = dst_init;
  assign ptr_adv[0]  = rd_w;
  assign ptr_adv[1]  = wr_w;
  assign ptr_step[0] = src_step_w;
  assign ptr_step[1] = dst_step_w;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    mcs_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_ni),
      .load     (load_w),
      .load_val (ptr_init[g]),
      .advance  (ptr_adv[g]),
      .step     (ptr_step[g]),
      .ptr      (ptr_val[g])
    );
  end

  mcs_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (load_w),
    .load_val (len_init),
    .dec      (rd_w),
    .cnt      (cnt_out),
    .zero     (cnt_zero_w)
  );

  // byte held from the read cycle into the write cycle
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (rd_w) data_q <= mem_rdata;
  end

  assign mem_rd    = rd_w;
  assign mem_wr    = wr_w;
  assign mem_addr  = wr_w ? ptr_val[1] : ptr_val[0];
  assign mem_wdata = data_q;
  assign src_out   = ptr_val[0];
  assign dst_out   = ptr_val[1];
  assign zero_flag = cnt_zero_w;

endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              busy,
  input logic              done,
  input logic              rep_mode,
  input logic              zero_flag,
  input logic [CNT_W-1:0]  cnt_out,
  input logic [ADDR_W-1:0] dst_out
);

  p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (cnt_out == $past(cnt_out) - CNT_W'(1)));

  p_zero_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (zero_flag == (cnt_out == '0)));

  p_dst_hold_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(dst_out));

  p_repeat_more_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && rep_mode && !zero_flag) |=> mem_rd);

  p_single_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !rep_mode) |=> (done && !busy));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !mem_wr && !busy));

endmodule

bind mem_copy_seq mcs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .busy      (busy),
  .done      (done),
  .rep_mode  (rep_mode_w),
  .zero_flag (zero_flag),
  .cnt_out   (cnt_out),
  .dst_out   (dst_out)
);

// File: tb/mem_copy_seq_tb.sv
module mem_copy_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  mode;
  logic [15:0] src_init, dst_init, len_init;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] src_out, dst_out, cnt_out;
  logic        zero_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 0;

  typedef struct {
    bit          is_wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] rem;
    bit          zero;
  } bus_item_t;

  bus_item_t exp_q[$];
  logic [7:0] mem [0:255];
  logic [7:0] shadow [0:255];

  mem_copy_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .src_init(src_init), .dst_init(dst_init), .len_init(len_init),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
    .cnt_out(cnt_out), .zero_flag(zero_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: asynchronous read, write at the clock edge
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] p, input logic [1:0] m);
    case (m)
      2'b01:   return p + 16'd1;
      2'b10:   return p - 16'd1;
      default: return p;
    endcase
  endfunction

  // monitor: pops one expected bus item per memory cycle
  always @(negedge clk) begin
    if (mon_on && (mem_rd || mem_wr)) begin
      chk(!(mem_rd && mem_wr), "R10", "rd and wr together", {mem_rd, mem_wr}, 0);
      if (exp_q.size() == 0) begin
        chk(0, "R9", "unexpected bus cycle at addr", int'(mem_addr), 0);
      end else begin
        bus_item_t it;
        it = exp_q.pop_front();
        chk(mem_wr == it.is_wr, "R2", "cycle kind (1=write)", int'(mem_wr), int'(it.is_wr));
        chk(mem_addr == it.addr, "R4", "bus address", int'(mem_addr), int'(it.addr));
        if (it.is_wr) begin
          chk(mem_wdata == it.data, "R2", "write data", int'(mem_wdata), int'(it.data));
          chk(cnt_out == it.rem, "R3", "count in write cycle", int'(cnt_out), int'(it.rem));
          chk(zero_flag == it.zero, "R3", "zero flag in write cycle", int'(zero_flag), int'(it.zero));
        end
      end
    end
  end

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] n, input logic [7:0] m,
                          input int poke_a, input int poke_b);
    int nbytes;
    int cyc;
    int exp_cyc;
    logic [15:0] rem;
    logic [7:0]  b;
    string rq;
    logic [15:0] es, ed;
    es = s; ed = d;
    nbytes = (n == 0) ? 0 : (m[4] ? int'(n) : 1);
    for (int i = 0; i < nbytes; i++) begin
      b = shadow[es[7:0]];
      shadow[ed[7:0]] = b;
      rem = n - 16'(i) - 16'd1;
      exp_q.push_back('{0, es, 8'h00, 16'h0, 0});
      exp_q.push_back('{1, ed, b, rem, rem == 0});
      es = step(es, m[1:0]);
      ed = step(ed, m[3:2]);
    end
    exp_cyc = 2 * nbytes + 1;
    rq = (n == 0) ? "R8" : (m[4] ? "R6" : "R7");

    start = 1'b1; mode = m; src_init = s; dst_init = d; len_init = n;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_a) || (cyc == poke_b);   // R9 pokes while busy
      if (start) begin
        src_init = 16'h1357; dst_init = 16'h2468; len_init = 16'd9; mode = 8'h1A;
      end
    end
    start = 1'b0;
    chk(cyc == exp_cyc, rq, "cycles until done", cyc, exp_cyc);
    chk(!busy, rq, "busy in done cycle", int'(busy), 0);
    chk(src_out == es, "R4", "final source pointer", int'(src_out), int'(es));
    chk(dst_out == ed, "R4", "final destination pointer", int'(dst_out), int'(ed));
    chk(cnt_out == n - 16'(nbytes), "R3", "final count", int'(cnt_out), int'(n - 16'(nbytes)));
    chk(zero_flag == (n - 16'(nbytes) == 0), rq, "final zero flag", int'(zero_flag),
        int'(n - 16'(nbytes) == 0));
    chk(exp_q.size() == 0, "R2", "bus items left over", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(!done, "R6", "done is one cycle wide", int'(done), 0);
    chk(!mem_rd && !mem_wr, "R6", "bus quiet after done", {mem_rd, mem_wr}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ls, ld, lc;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i) ^ 8'hA5;
      shadow[i] = 8'(i) ^ 8'hA5;
    end
    rst_n = 1'b0; start = 1'b0; mode = '0;
    src_init = '0; dst_init = '0; len_init = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!mem_rd && !mem_wr, "R1", "bus idle after reset", {mem_rd, mem_wr}, 0);
    chk(src_out == 0 && dst_out == 0, "R1", "pointers after reset", int'({src_out, dst_out}), 0);
    chk(cnt_out == 0 && zero_flag, "R1", "count/zero after reset", int'({cnt_out, zero_flag}), 1);
    mon_on = 1;

    // R6 repeat, both up
    run_copy(16'h0010, 16'h0040, 16'd5, 8'h15, 0, 0);
    // R4 both down
    run_copy(16'h002F, 16'h006F, 16'd4, 8'h1A, 0, 0);
    // R4 source held, destination up (fill)
    run_copy(16'h0003, 16'h0090, 16'd3, 8'h14, 0, 0);
    // R4 reserved source code holds, dst down, upper mode bits set
    run_copy(16'h0005, 16'h00B0, 16'd3, 8'hFB, 0, 0);
    // R5 wrap in both directions
    run_copy(16'hFFFE, 16'h0001, 16'd3, 8'h19, 0, 0);
    // R8 zero count
    run_copy(16'h0020, 16'h0030, 16'd0, 8'h15, 0, 0);
    // R3 single-byte repeat run: zero valid in the only write
    run_copy(16'h0050, 16'h0060, 16'd1, 8'h15, 0, 0);
    // R9 start poked mid-run and in the final write cycle
    run_copy(16'h0070, 16'h00C0, 16'd4, 8'h15, 3, 8);
    // R7 single mode, loop fed from the outputs
    ls = 16'h00A0; ld = 16'h00D0; lc = 16'd3;
    for (int k = 0; k < 3; k++) begin
      run_copy(ls, ld, lc, 8'h05, 0, 0);
      ls = src_out; ld = dst_out; lc = cnt_out;
    end
    chk(zero_flag, "R7", "single loop ends with zero", int'(zero_flag), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule